// File: doc/BRIEF.md
# Instruction memory byte-window loader

This block lets a host with an 8-bit register port fill and inspect a 32-bit-wide instruction memory. The host sees four byte registers: a control register, a data window, and a low and a high word-address register. A word is loaded by writing its four bytes to the window one after another, least significant byte first. The block holds the first three bytes in a staging register. On the fourth byte it writes the whole word into the internal RAM and moves the word address on by one.

Reads through the window return the bytes of the stored word at the current address in the same lane order. They step the byte lane and the address exactly as writes do, so a whole program can be dumped back in one pass. The window only responds while the load-enable bit is set. A self-clearing reset bit in the control register returns the address and the lane to zero.

There is one host access per cycle, qualified by `acc_valid_i`. Read data is combinational from the current state and is valid in the same cycle as the access. The register select encoding is: 0 control, 1 data window, 2 address low, 3 address high.

Top module: `seq_ram_loader`

## Requirements
- R1: After reset, reads of the control, address-low and address-high registers return 0x00.
- R2: Four consecutive window writes (lanes 0..3, least significant byte first) store one 32-bit word at the current word address; the word reads back byte for byte in the same lane order.
- R3: The word address is unchanged after the first, second and third window write of a word and has increased by one after the fourth.
- R4: The address-high register holds only address bit 8 in its bit 0; writing 0xFF to it reads back 0x01, and the low register is not affected.
- R5: Window writes while the load-enable bit (control bit 0) is 0 change neither the RAM, nor the word address, nor the byte lane.
- R6: Window reads while load-enable is 0 return 0x00 and do not advance the byte lane.
- R7: A write to either address register sets the byte lane back to 0, so a partly written word is dropped and the next window byte is lane 0.
- R8: Writing control with bit 1 set zeroes the word address and the byte lane in one access; bit 1 always reads back as 0, while bit 0 takes the written value.
- R9: Window reads return the byte of the current lane of the word at the current address, and they advance the lane and the address exactly as writes do.
- R10: The word address wraps from the last word (511 at default depth) to 0 after the fourth byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Host access in this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_sel_i | input | 2 | Register select: 0 control, 1 window, 2 address low, 3 address high |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Read data for the selected register, valid in the access cycle |

## Verification
Read data depends only on the current state, so the bench samples `acc_rdata_o` 1 ns after the falling edge on which it drives the access, before the next rising edge. Every state change (lane step, address increment, RAM commit, address load, soft reset) lands on the rising edge that ends the access. The bench therefore checks its effect in the next access, two edges after the stimulus and never earlier. The bench sweeps all 512 words with an arithmetic pattern and reads them back. It checks the address between bytes, at the wrap, and around address loads, soft reset and disabled windows.

// File: rtl/seq_ld_pkg.sv
package seq_ld_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_WIN     = 2'd1,
    SEL_ADDR_LO = 2'd2,
    SEL_ADDR_HI = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_LOAD_BIT = 0;
  localparam int unsigned CTRL_RST_BIT  = 1;
  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned LANES         = 4;
  localparam int unsigned LANE_W        = $clog2(LANES);
endpackage

// File: rtl/seq_ld_ctrl.sv
module seq_ld_ctrl
  import seq_ld_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       acc_valid_i,
  input  logic                       acc_write_i,
  input  logic [1:0]                 acc_sel_i,
  input  logic [BYTE_W-1:0]          acc_wdata_i,
  output logic                       load_en_o,
  output logic [ADDR_W-1:0]          addr_o,
  output logic [LANE_W-1:0]          lane_o,
  output logic                       win_wr_o,
  output logic                       win_rd_o
);
  localparam int unsigned HI_W = ADDR_W - BYTE_W;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic              load_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic              is_win, ctrl_wr, lo_wr, hi_wr, step;

  assign is_win  = acc_valid_i && (reg_sel_e'(acc_sel_i) == SEL_WIN);
  assign ctrl_wr = acc_valid_i && acc_write_i && (reg_sel_e'(acc_sel_i) == SEL_CTRL);
  assign lo_wr   = acc_valid_i && acc_write_i && (reg_sel_e'(acc_sel_i) == SEL_ADDR_LO);
  assign hi_wr   = acc_valid_i && acc_write_i && (reg_sel_e'(acc_sel_i) == SEL_ADDR_HI);

  assign win_wr_o = is_win && acc_write_i && load_q;
  assign win_rd_o = is_win && !acc_write_i && load_q;
  assign step     = win_wr_o || win_rd_o;

  always_comb begin
    addr_d = addr_q;
    lane_d = lane_q;
    if (ctrl_wr && acc_wdata_i[CTRL_RST_BIT]) begin
      addr_d = '0;
      lane_d = '0;
    end else if (lo_wr) begin
      addr_d[BYTE_W-1:0] = acc_wdata_i;
      lane_d             = '0;
    end else if (hi_wr) begin
      addr_d[ADDR_W-1:BYTE_W] = acc_wdata_i[HI_W-1:0];
      lane_d                  = '0;
    end else if (step) begin
      lane_d = lane_q + 1'b1;
      if (lane_q == LAST_LANE) addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      addr_q <= '0;
      lane_q <= '0;
    end else begin
      if (ctrl_wr) load_q <= acc_wdata_i[CTRL_LOAD_BIT];
      addr_q <= addr_d;
      lane_q <= lane_d;
    end
  end

  assign load_en_o = load_q;
  assign addr_o    = addr_q;
  assign lane_o    = lane_q;

  // R3
  lane_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && lane_q == LAST_LANE) |=> (lane_q == '0 && addr_q == ADDR_W'($past(addr_q) + 1'b1)));

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && lane_q != LAST_LANE) |=> ($stable(addr_q) && lane_q == LANE_W'($past(lane_q) + 1'b1)));

  // R5
  win_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_win && !load_q) |=> ($stable(addr_q) && $stable(lane_q)));

  // R7
  addr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_wr || hi_wr) |=> (lane_q == '0));

  // R8
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && acc_wdata_i[CTRL_RST_BIT]) |=> (addr_q == '0 && lane_q == '0));
endmodule

// File: rtl/seq_ld_pack.sv
module seq_ld_pack
  import seq_ld_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [LANE_W-1:0]        lane_i,
  input  logic [BYTE_W-1:0]        byte_i,
  output logic                     ram_we_o,
  output logic [LANES*BYTE_W-1:0]  ram_wdata_o
);
  localparam int unsigned STAGE_LANES = LANES - 1;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic [STAGE_LANES*BYTE_W-1:0] stage_q;

  for (genvar g = 0; g < STAGE_LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g*BYTE_W +: BYTE_W] <= '0;
      else if (wr_i && lane_i == LANE_W'(g)) stage_q[g*BYTE_W +: BYTE_W] <= byte_i;
    end
  end

  assign ram_we_o    = wr_i && (lane_i == LAST_LANE);
  assign ram_wdata_o = {byte_i, stage_q};
endmodule

// File: rtl/seq_ld_ram.sv
module seq_ld_ram #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/seq_ram_loader.sv
module seq_ram_loader
  import seq_ld_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_valid_i,
  input  logic       acc_write_i,
  input  logic [1:0] acc_sel_i,
  input  logic [7:0] acc_wdata_i,
  output logic [7:0] acc_rdata_o
);
  localparam int unsigned WORD_W = LANES * BYTE_W;
  localparam int unsigned HI_W   = ADDR_W - BYTE_W;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic              load_en;
  logic [ADDR_W-1:0] addr;
  logic [LANE_W-1:0] lane;
  logic              win_wr, win_rd;
  logic              ram_we;
  logic [WORD_W-1:0] ram_wdata, ram_rdata;
  logic [BYTE_W-1:0] win_byte;

  seq_ld_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid_i),
    .acc_write_i (acc_write_i),
    .acc_sel_i   (acc_sel_i),
    .acc_wdata_i (acc_wdata_i),
    .load_en_o   (load_en),
    .addr_o      (addr),
    .lane_o      (lane),
    .win_wr_o    (win_wr),
    .win_rd_o    (win_rd)
  );

  seq_ld_pack u_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (win_wr),
    .lane_i      (lane),
    .byte_i      (acc_wdata_i),
    .ram_we_o    (ram_we),
    .ram_wdata_o (ram_wdata)
  );

  seq_ld_ram #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .addr_i  (addr),
    .wdata_i (ram_wdata),
    .rdata_o (ram_rdata)
  );

  assign win_byte = ram_rdata[lane*BYTE_W +: BYTE_W];

  always_comb begin
    unique case (reg_sel_e'(acc_sel_i))
      SEL_CTRL:    acc_rdata_o = BYTE_W'(load_en);
      SEL_WIN:     acc_rdata_o = load_en ? win_byte : '0;
      SEL_ADDR_LO: acc_rdata_o = addr[BYTE_W-1:0];
      SEL_ADDR_HI: acc_rdata_o = BYTE_W'(addr[ADDR_W-1:BYTE_W]);
      default:     acc_rdata_o = '0;
    endcase
  end

  // R2
  commit_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |-> (lane == LAST_LANE && load_en && acc_write_i));

  // R6
  win_off_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_write_i && reg_sel_e'(acc_sel_i) == SEL_WIN && !load_en)
      |-> (acc_rdata_o == '0));

  // R4
  hi_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_e'(acc_sel_i) == SEL_ADDR_HI) |-> (acc_rdata_o[BYTE_W-1:HI_W] == '0));
endmodule

// File: tb/tb_seq_ram_loader.sv
module tb_seq_ram_loader;
  localparam int unsigned NWORDS = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_write = 1'b0;
  logic [1:0] acc_sel = 2'd0;
  logic [7:0] acc_wdata = 8'h00;
  logic [7:0] acc_rdata;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  seq_ram_loader dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .acc_valid_i (acc_valid),
    .acc_write_i (acc_write),
    .acc_sel_i   (acc_sel),
    .acc_wdata_i (acc_wdata),
    .acc_rdata_o (acc_rdata)
  );

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h9E37_79B1) ^ 32'h5A3C_0F00 ^ 32'(i);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_sel = sel; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_sel = sel;
    #1 d = acc_rdata;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic wr_word(input logic [31:0] w);
    for (int b = 0; b < 4; b++) wr(2'd1, w[b*8 +: 8]);
  endtask

  task automatic rd_word(output logic [31:0] w);
    logic [7:0] t;
    for (int b = 0; b < 4; b++) begin
      rd(2'd1, t);
      w[b*8 +: 8] = t;
    end
  endtask

  task automatic set_addr(input int a);
    wr(2'd3, 8'(a >> 8));
    wr(2'd2, 8'(a));
  endtask

  task automatic chk_addr(input string req, input int exp);
    logic [7:0] lo, hi;
    rd(2'd2, lo);
    rd(2'd3, hi);
    check(req, {16'h0, hi, lo}, 32'(exp));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, b); check("R1 ctrl", 32'(b), 32'h0);
    chk_addr("R1 addr", 0);

    wr(2'd0, 8'h01);
    // R2 R3 R10 full sweep, address watched between bytes on word 0
    for (int i = 0; i < NWORDS; i++) begin
      w = pat(i);
      if (i == 0) begin
        for (int k = 0; k < 4; k++) begin
          wr(2'd1, w[k*8 +: 8]);
          chk_addr("R3 after byte", (k == 3) ? 1 : 0);
        end
      end else begin
        wr_word(w);
      end
    end
    chk_addr("R10 wrap", 0);

    // R9 R2 readback sweep
    for (int i = 0; i < NWORDS; i++) begin
      if (i == 0) begin
        for (int k = 0; k < 4; k++) begin
          rd(2'd1, b);
          check("R9 read byte", 32'(b), 32'(pat(0)[k*8 +: 8]));
          chk_addr("R9 read addr step", (k == 3) ? 1 : 0);
        end
      end else begin
        rd_word(w);
        check("R2 readback", w, pat(i));
      end
    end
    chk_addr("R10 read wrap", 0);

    // R4 high register is one bit
    wr(2'd3, 8'hFF);
    rd(2'd3, b); check("R4 hi", 32'(b), 32'h01);
    rd(2'd2, b); check("R4 lo kept", 32'(b), 32'h00);
    wr(2'd2, 8'h05);
    chk_addr("R4 addr", 261);
    rd_word(w); check("R4 word", w, pat(261));

    // R7 address write drops partial word
    set_addr(10);
    wr(2'd1, 8'hAA); wr(2'd1, 8'hBB);
    wr(2'd2, 8'd10);
    wr_word(32'hC0DE_F00D);
    chk_addr("R7 addr", 11);
    set_addr(10);
    rd_word(w); check("R7 word", w, 32'hC0DE_F00D);

    // R5 R6 window disabled
    set_addr(20);
    wr(2'd0, 8'h00);
    for (int k = 0; k < 4; k++) wr(2'd1, 8'hEE);
    rd(2'd1, b); check("R6 read off", 32'(b), 32'h0);
    rd(2'd1, b); check("R6 read off", 32'(b), 32'h0);
    rd(2'd0, b); check("R5 ctrl", 32'(b), 32'h0);
    chk_addr("R5 addr", 20);
    wr(2'd0, 8'h01);
    rd(2'd1, b); check("R6 lane kept", 32'(b), 32'(pat(20)[7:0]));
    set_addr(20);
    rd_word(w); check("R5 ram kept", w, pat(20));

    // R8 soft reset
    set_addr(100);
    wr(2'd1, 8'h77);
    wr(2'd0, 8'h03);
    rd(2'd0, b); check("R8 ctrl", 32'(b), 32'h01);
    chk_addr("R8 addr", 0);
    rd_word(w); check("R8 lane", w, pat(0));

    finish_run();
  end
endmodule